// File: doc/BRIEF.md
# Toggle-Request Falling-Edge Word RAM

This block is a single-port word memory placed beside a controller that updates on the rising clock edge. The controller never reaches into the storage. Instead it presents four things: a byte address, a write select, write data and a one-bit request flag. An access is requested by flipping the flag. The flag is not raised and lowered.

The memory side runs on the falling clock edge. It keeps a private copy of the flag value it last served and performs exactly one access on any falling edge where that copy and the controller's flag disagree. The access brings the copy back into agreement with the flag, so the memory disarms itself with no extra controller state.

A store issued in a controller state is complete before that state ends. Load data is registered at the falling edge inside the issuing cycle, so the controller can capture it at the very next rising edge. Byte addresses are rebased against a fixed base and divided by four to select a word.

Top module: `togl_word_ram`

## Requirements
- R1: The word index is ((byte_addr - BASE_ADDR) >> 2) truncated to log2(DEPTH) bits, so byte_addr bits [1:0] have no effect and an address DEPTH words above the base wraps to word 0.
- R2: While rst_n is low, the served-flag copy is cleared to 0. Memory contents are kept across reset. After reset, a req_tgl held at 0 performs no access.
- R3: An access occurs on a falling clock edge only when req_tgl differs from the served-flag copy.
- R4: After an access, the copy equals req_tgl. While req_tgl is held constant, no further access occurs: no word is written and rdata does not change, whatever wr_req, byte_addr and wdata do.
- R5: On an access with wr_req = 1, wdata is written to the indexed word and rdata keeps its previous value.
- R6: On an access with wr_req = 0, rdata is loaded with the indexed word at the falling edge of the issuing cycle. It is valid before the next rising edge.
- R7: Toggling req_tgl in consecutive cycles performs one access per cycle, with no idle cycle required between them.
- R8: A load issued in the cycle right after a store to the same word returns the stored data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the controller uses the rising edge, the memory uses the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_tgl | input | 1 | Request flag; each change of value requests one access |
| wr_req | input | 1 | 1 selects a store, 0 selects a load |
| byte_addr | input | ADDR_W | Byte address of the access |
| wdata | input | DATA_W | Store data |
| rdata | output | DATA_W | Registered load data |

## Verification
The checker assumes that the controller changes req_tgl, wr_req, byte_addr and wdata only just after a rising edge, so the values are steady at the falling edge that uses them. It also assumes that the controller drives req_tgl to 0 while reset is held, matching the cleared copy. The bench drives every input one nanosecond after a rising edge and holds req_tgl at 0 during reset. It reads rdata one nanosecond after the falling edge, which keeps every stimulus inside those assumptions.

// File: rtl/trw_pkg.sv
package trw_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_SHIFT = $clog2(WORD_BYTES);

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } trw_op_e;
endpackage

// File: rtl/trw_addr_xlate.sv
module trw_addr_xlate
  import trw_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned IDX_W  = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic [ADDR_W-1:0] byte_addr,
  output logic [IDX_W-1:0]  word_idx
);
  logic [ADDR_W-1:0] rebased;

  always_comb begin
    rebased  = byte_addr - BASE_ADDR;
    word_idx = IDX_W'(rebased >> WORD_SHIFT);
  end
endmodule

// File: rtl/trw_req_track.sv
module trw_req_track (
  input  logic clk,
  input  logic rst_n,
  input  logic req_tgl,
  output logic fire
);
  logic served_q;
  logic served_d;

  always_comb begin
    fire     = (served_q != req_tgl);
    served_d = fire ? req_tgl : served_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      served_q <= 1'b0;
    end else begin
      served_q <= served_d;
    end
  end
endmodule

// File: rtl/trw_store.sv
module trw_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              fire,
  input  logic              wr_req,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] words [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(negedge clk) begin
    if (fire) begin
      if (wr_req) begin
        words[word_idx] <= wdata;
      end else begin
        rd_q <= words[word_idx];
      end
    end
  end

  assign rdata = rd_q;
endmodule

// File: rtl/togl_word_ram.sv
module togl_word_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             fire;
  logic [IDX_W-1:0] word_idx;

  trw_addr_xlate #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_xlate (
    .byte_addr(byte_addr),
    .word_idx (word_idx)
  );

  trw_req_track u_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_tgl(req_tgl),
    .fire   (fire)
  );

  trw_store #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) u_mem (
    .clk     (clk),
    .fire    (fire),
    .wr_req  (wr_req),
    .word_idx(word_idx),
    .wdata   (wdata),
    .rdata   (rdata)
  );
endmodule

// File: rtl/trw_checker.sv
module trw_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_tgl,
  input logic              wr_req,
  input logic              fire,
  input logic [DATA_W-1:0] rdata
);
  // R2: with the flag held low in reset, nothing is armed
  always @(negedge clk) begin
    if (!rst_n && !req_tgl) begin
      a_reset_idle_r2: assert (!fire) else $error("armed during reset");
    end
  end

  // R4: once served, the memory stays idle unless the flag moves again
  p_disarm_r4: assert property (@(negedge clk) disable iff (!rst_n)
    fire |=> (!fire || (req_tgl != $past(req_tgl))));

  // R3: an idle edge with a steady flag stays idle
  p_idle_stays_r3: assert property (@(negedge clk) disable iff (!rst_n)
    !fire |=> (!fire || (req_tgl != $past(req_tgl))));

  // R4: no access, no change on read data
  p_idle_rdata_r4: assert property (@(negedge clk) disable iff (!rst_n)
    !fire |=> $stable(rdata));

  // R5: a store leaves read data untouched
  p_store_keeps_r5: assert property (@(negedge clk) disable iff (!rst_n)
    (fire && wr_req) |=> $stable(rdata));
endmodule

bind togl_word_ram trw_checker #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req_tgl(req_tgl),
  .wr_req (wr_req),
  .fire   (fire),
  .rdata  (rdata)
);

// File: tb/sim_togl_word_ram.sv
`timescale 1ns/1ps
module sim_togl_word_ram;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0100;
  localparam int NVEC = 9;
  localparam int VW = 1 + AW + DW + DW;

  // entry: {store, byte address, write data, expected load data}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {1'b1, 16'h0100, 32'h1111_1111, 32'h0},
    {1'b1, 16'h0104, 32'h2222_2222, 32'h0},
    {1'b1, 16'h04FC, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 16'h0100, 32'h0,         32'h1111_1111},
    {1'b0, 16'h04FC, 32'h0,         32'hDEAD_BEEF},
    {1'b0, 16'h0106, 32'h0,         32'h2222_2222},
    {1'b1, 16'h0500, 32'hA5A5_A5A5, 32'h0},
    {1'b0, 16'h0100, 32'h0,         32'hA5A5_A5A5},
    {1'b0, 16'h0104, 32'h0,         32'h2222_2222}
  };

  logic          clk;
  logic          rst_n;
  logic          req_tgl;
  logic          wr_req;
  logic [AW-1:0] byte_addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;

  int n_run;
  int n_fail;

  togl_word_ram #(.DATA_W(DW), .DEPTH(256), .ADDR_W(AW), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .req_tgl(req_tgl), .wr_req(wr_req),
    .byte_addr(byte_addr), .wdata(wdata), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // issue one access just after a rising edge, return once it is served
  task automatic access(input logic st, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk);
    #1;
    wr_req    = st;
    byte_addr = a;
    wdata     = d;
    req_tgl   = ~req_tgl;
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] prev;
    logic [DW-1:0] sum_ref;
    logic [DW-1:0] sum_dut;
    n_run = 0;
    n_fail = 0;
    rst_n = 1'b0;
    req_tgl = 1'b0;
    wr_req = 1'b0;
    byte_addr = BASE;
    wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // table walk: R1 indexing, R5 stores, R6 loads
    for (int i = 0; i < NVEC; i++) begin
      prev = rdata;
      access(VEC[i][VW-1], VEC[i][VW-2 -: AW], VEC[i][2*DW-1 -: DW]);
      if (VEC[i][VW-1]) check("R5 store keeps rdata", rdata, prev);
      else              check("R1/R6 load", rdata, VEC[i][DW-1:0]);
    end

    // R4: steady flag, busy inputs, no access
    access(1'b1, BASE + 16'd12, 32'h3333_3333);
    access(1'b0, BASE + 16'd4, 32'h0);
    prev = rdata;
    for (int c = 0; c < 40; c++) begin
      @(posedge clk);
      #1;
      wr_req = c[0];
      byte_addr = BASE + 16'd12;
      wdata = 32'h0BAD_0000 + c;
      @(negedge clk);
      #1;
      if (c % 10 == 0) check("R4 rdata held", rdata, prev);
    end
    access(1'b0, BASE + 16'd12, 32'h0);
    check("R4 no stray write", rdata, 32'h3333_3333);

    // R2: reset with flag copy at 1, controller flag cleared
    if (req_tgl !== 1'b1) access(1'b0, BASE, 32'h0);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    req_tgl = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    wr_req = 1'b1;
    byte_addr = BASE;
    wdata = 32'hFFFF_0000;
    repeat (4) @(posedge clk);
    access(1'b0, BASE, 32'h0);
    check("R2 memory kept, no access after reset", rdata, 32'hA5A5_A5A5);

    // R7/R8: a store and a load every cycle, no gaps
    for (int k = 0; k < 4; k++) begin
      access(1'b1, BASE + 16'(4 * (40 + k)), 32'hC000_0000 + k);
      access(1'b0, BASE + 16'(4 * (40 + k)), 32'h0);
      check("R7/R8 back-to-back load", rdata, 32'hC000_0000 + k);
    end

    // R6: store a series, reload and accumulate like a controller
    sum_ref = '0;
    for (int k = 0; k < 8; k++) begin
      access(1'b1, BASE + 16'(4 * (16 + k)), 32'(k * 7 + 3));
      sum_ref += 32'(k * 7 + 3);
    end
    sum_dut = '0;
    for (int k = 0; k < 8; k++) begin
      access(1'b0, BASE + 16'(4 * (16 + k)), 32'h0);
      sum_dut += rdata;
    end
    check("R6 accumulated sum", sum_dut, sum_ref);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule